// File: doc/BRIEF.md
# Group-One Operate Microinstruction Unit

This unit carries out the first group of operate microinstructions of a 12-bit accumulator machine. An operate word packs several independent micro-operations into one instruction: clearing, complementing, incrementing, and rotating the accumulator and its one-bit link. The unit applies whichever of them the word selects in a fixed order of stages and returns the new accumulator and link.

The caller presents the instruction, the current accumulator and the current link with `in_valid` high for one cycle. On the next clock edge the unit registers the result and raises `done` for exactly one cycle. The outputs then hold their values until the next request. A word outside the group-one pattern passes the accumulator and link through unchanged and raises `ignored` together with `done`.

Bit numbering below counts bit 0 as the most significant bit of `instr`, so bit k is `instr[11-k]`. The pattern is bits 0..2 = 111 and bit 3 = 0. The micro-operation bits are: clear accumulator (bit 4), clear link (bit 5), complement accumulator (bit 6), complement link (bit 7), rotate right (bit 8), rotate left (bit 9), double-step select (bit 10), and increment (bit 11).

Top module: `opr1_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request, `acc_out`, `link_out`, `done` and `ignored` are all 0.
- R2: A cycle with `in_valid` high is followed by exactly one cycle with `done` high. `done` is low in every other cycle.
- R3: With no request, `acc_out` and `link_out` keep their last values.
- R4: Bit 4 clears the accumulator and bit 5 clears the link before any other stage runs.
- R5: Bit 6 inverts the accumulator and bit 7 inverts the link, after the clear stage.
- R6: Bit 11 adds one to the 13-bit value {link, accumulator}, so a carry out of the accumulator inverts the link.
- R7: With bit 10 at 0, bit 8 rotates the 13-bit ring {link, accumulator} right by one place and bit 9 rotates it left by one place.
- R8: With bit 10 at 1, bit 8 or bit 9 rotates the same ring by two places.
- R9: With bits 8 and 9 both 0 and bit 10 at 1, the upper and lower 6-bit halves of the accumulator are exchanged and the link is unchanged.
- R10: With bits 8 and 9 both 1, the unit performs neither a rotate nor a swap, whatever bit 10 holds. The earlier stages still apply.
- R11: If bits 0..3 are not 1110, the result equals the input accumulator and link and `ignored` is 1 during the `done` cycle. Otherwise `ignored` is 0 during the `done` cycle.
- R12: The increment stage comes after the complement stage and before the rotate or swap stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| instr | input | 12 | Operate word, bit 0 is `instr[11]` |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link |
| acc_out | output | 12 | Registered new accumulator |
| link_out | output | 1 | Registered new link |
| done | output | 1 | One-cycle pulse after each request |
| ignored | output | 1 | Set with `done` when the word is not group one |

## Verification
The bound checker checks the handshake and the pass-through rules on every cycle. These are the one-cycle `done` pulse, the holding of the outputs while idle, the unchanged result for a word outside group one, and the all-ones accumulator that a clear followed by a complement must give. How the stages combine can only be shown by the bench's vectors. These vectors cover the 13-bit carry into the link, single and double rotates through the link, the byte-swap encoding, the cancelling of two rotate directions, and the ordering of increment against complement and rotate.

// File: rtl/opr1_unit.sv
module opr1_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [11:0]  instr,
  input  logic [W-1:0] acc_in,
  input  logic         link_in,
  output logic [W-1:0] acc_out,
  output logic         link_out,
  output logic         done,
  output logic         ignored
);
  localparam int H = W / 2;

  logic match;
  logic f_cla, f_cll, f_cma, f_cml, f_rr, f_rl, f_two, f_inc;
  logic [W:0] s_clr, s_cmp, s_inc, s_rot;

  assign match = (instr[11:8] == 4'b1110);
  assign f_cla = instr[7];
  assign f_cll = instr[6];
  assign f_cma = instr[5];
  assign f_cml = instr[4];
  assign f_rr  = instr[3];
  assign f_rl  = instr[2];
  assign f_two = instr[1];
  assign f_inc = instr[0];

  assign s_clr = {link_in & ~f_cll, acc_in & {W{~f_cla}}};
  assign s_cmp = s_clr ^ {f_cml, {W{f_cma}}};
  assign s_inc = s_cmp + {{W{1'b0}}, f_inc};

  always_comb begin
    s_rot = s_inc;
    if (f_rr && !f_rl)
      s_rot = f_two ? {s_inc[1:0], s_inc[W:2]} : {s_inc[0], s_inc[W:1]};
    else if (f_rl && !f_rr)
      s_rot = f_two ? {s_inc[W-2:0], s_inc[W:W-1]} : {s_inc[W-1:0], s_inc[W]};
    else if (!f_rr && !f_rl && f_two)
      s_rot = {s_inc[W], s_inc[H-1:0], s_inc[W-1:H]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out  <= '0;
      link_out <= 1'b0;
      done     <= 1'b0;
      ignored  <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        ignored <= ~match;
        if (match) {link_out, acc_out} <= s_rot;
        else       {link_out, acc_out} <= {link_in, acc_in};
      end
    end
  end
endmodule

module opr1_unit_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [11:0]  instr,
  input logic [W-1:0] acc_in,
  input logic         link_in,
  input logic [W-1:0] acc_out,
  input logic         link_out,
  input logic         done,
  input logic         ignored
);
  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  // R2
  done_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_out) && $stable(link_out)));

  // R11
  foreign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:8] != 4'b1110) |=>
      (ignored && acc_out == $past(acc_in) && link_out == $past(link_in)));

  // R11
  member_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:8] == 4'b1110) |=> !ignored);

  // R5
  clear_then_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:8] == 4'b1110 && instr[7] && instr[5] && instr[3:0] == 4'b0000)
      |=> (acc_out == {W{1'b1}}));
endmodule

bind opr1_unit opr1_unit_chk #(.W(W)) u_chk (.*);

// File: tb/opr1_unit_test.sv
module opr1_unit_test;
  localparam time TCLK = 10ns;
  localparam int  NV = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] acc_out;
  logic        link_out;
  logic        done;
  logic        ignored;

  int n_chk = 0;
  int n_bad = 0;

  // {instr, link_in, acc_in, link_exp, acc_exp, ignored_exp}
  localparam logic [38:0] VEC [NV] = '{
    {12'o7300, 1'b1, 12'o5555, 1'b0, 12'o0000, 1'b0},  // R4
    {12'o7240, 1'b0, 12'o1234, 1'b0, 12'o7777, 1'b0},  // R5
    {12'o7120, 1'b0, 12'o1234, 1'b1, 12'o1234, 1'b0},  // R5
    {12'o7041, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0},  // R12
    {12'o7001, 1'b0, 12'o7777, 1'b1, 12'o0000, 1'b0},  // R6
    {12'o7001, 1'b1, 12'o0005, 1'b1, 12'o0006, 1'b0},  // R6
    {12'o7010, 1'b0, 12'o0001, 1'b1, 12'o0000, 1'b0},  // R7
    {12'o7004, 1'b1, 12'o4000, 1'b1, 12'o0001, 1'b0},  // R7
    {12'o7012, 1'b0, 12'o0003, 1'b1, 12'o4000, 1'b0},  // R8
    {12'o7006, 1'b0, 12'o6000, 1'b1, 12'o0001, 1'b0},  // R8
    {12'o7002, 1'b1, 12'o1234, 1'b1, 12'o3412, 1'b0},  // R9
    {12'o7016, 1'b0, 12'o1234, 1'b0, 12'o1234, 1'b0},  // R10
    {12'o7015, 1'b0, 12'o0007, 1'b0, 12'o0010, 1'b0},  // R10
    {12'o7045, 1'b0, 12'o0000, 1'b0, 12'o0001, 1'b0},  // R12
    {12'o7203, 1'b1, 12'o1234, 1'b1, 12'o0100, 1'b0},  // R12
    {12'o1234, 1'b1, 12'o4321, 1'b1, 12'o4321, 1'b1},  // R11
    {12'o7400, 1'b0, 12'o0707, 1'b0, 12'o0707, 1'b1}   // R11
  };

  opr1_unit uut (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got {done,link,acc}=%b_%b_%o expected %b_%b_%o", req,
               got[13], got[12], got[11:0], exp[13], exp[12], exp[11:0]);
    end
  endtask

  task automatic request(input logic [11:0] w, input logic l, input logic [11:0] a);
    @(negedge clk);
    instr = w; link_in = l; acc_in = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", {done, link_out, acc_out}, 14'b0);
    check("R1 ignored", {13'b0, ignored}, 14'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {done, link_out, acc_out}, 14'b0);

    for (int i = 0; i < NV; i++) begin
      request(VEC[i][38:27], VEC[i][26], VEC[i][25:14]);
      check($sformatf("vector %0d result (R4-R12 set)", i),
            {done, link_out, acc_out}, {1'b1, VEC[i][13:1]});
      check($sformatf("vector %0d R11 ignored flag", i),
            {13'b0, ignored}, {13'b0, VEC[i][0]});
    end

    // R2: pulse lasts one cycle; R3: outputs hold while idle
    request(12'o7240, 1'b1, 12'o0000);
    check("R2 pulse high", {done, link_out, acc_out}, {1'b1, 1'b1, 12'o7777});
    @(negedge clk);
    check("R2 pulse low / R3 hold", {done, link_out, acc_out}, {1'b0, 1'b1, 12'o7777});
    instr = 12'o7300; acc_in = 12'o0000; link_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 hold with idle inputs changing", {done, link_out, acc_out}, {1'b0, 1'b1, 12'o7777});

    // R2: back-to-back requests give back-to-back pulses
    @(negedge clk);
    instr = 12'o7001; link_in = 1'b0; acc_in = 12'o0010; in_valid = 1'b1;
    @(negedge clk);
    check("R2 back-to-back first", {done, link_out, acc_out}, {1'b1, 1'b0, 12'o0011});
    instr = 12'o7010; link_in = 1'b1; acc_in = 12'o0002;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 back-to-back second", {done, link_out, acc_out}, {1'b1, 1'b0, 12'o4001});

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {done, link_out, acc_out}, 14'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule